// File: doc/BRIEF.md
# Bridge Port Admission and Nack Control

This block sits on one side of a two-port bus bridge and decides, for every packet arriving at that side, whether the packet crosses the bridge or is bounced back to its sender as a negative acknowledgement (nack). The bridge never stalls an incoming packet. When there is no room for the packet, it turns the packet around. The decision is registered, so it appears one clock after the packet is presented.

Two independent occupancy counters drive the decision, and each has its own limit parameter. The first counts requests waiting in this side's outbound request queue. Its full flag goes to the opposite side's admission logic, and the opposite side's flag comes in here. The second counts response slots reserved for forwarded packets that still expect a reply. A forwarded packet becomes eligible to leave after the crossing delay. A nack becomes eligible after a separate turnaround delay. Both eligibility times are computed modulo 2^TIME_W from the current time input.

Top module: `bridge_admit`

## Requirements
- R1: After synchronous reset both counters read zero, `req_full_o` is low, and neither `fwd_o` nor `nack_o` is asserted.
- R2: A packet with `pkt_is_req_i`=1 presented while `far_req_full_i`=1 is nacked one cycle later with `nack_cause_o`=0. A non-request packet is not nacked for this reason. This cause takes priority over the response-full cause.
- R3: A packet with `pkt_needs_resp_i`=1 and `pkt_nacked_i`=0 that is not nacked under R2 is nacked with `nack_cause_o`=1 when the outstanding-response count is at or above RESP_LIMIT.
- R4: A packet that is not nacked is forwarded one cycle after it is presented. `fwd_dst_o` equals its destination and `fwd_ready_o` = `now_i` + CROSS_DLY, modulo 2^TIME_W.
- R5: A nack returns to the originator. `nack_dst_o` equals the packet's source and `nack_ready_o` = `now_i` + NACK_DLY, modulo 2^TIME_W, independent of CROSS_DLY.
- R6: Forwarding a packet with `pkt_needs_resp_i`=1 and `pkt_nacked_i`=0 adds one to the outstanding-response count. `resp_done_i` subtracts one. When both happen in the same cycle the count is unchanged. An already-nacked packet reserves nothing.
- R7: `req_enq_i` adds one to the queued-request count and `req_sent_i` subtracts one. `req_full_o` is high exactly when that count is at or above REQ_LIMIT.
- R8: Neither counter leaves the range 0 to its limit. An increment at the limit is ignored, and a decrement at zero is ignored.
- R9: Each presented packet produces exactly one of `fwd_o` or `nack_o`, for one cycle. Neither strobe is asserted in a cycle that follows one with no packet presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now_i | input | TIME_W | Current time |
| pkt_valid_i | input | 1 | A packet is presented this cycle |
| pkt_is_req_i | input | 1 | Packet is a request |
| pkt_needs_resp_i | input | 1 | Packet expects a response |
| pkt_nacked_i | input | 1 | Packet is already a nack |
| pkt_src_i | input | ID_W | Source ID |
| pkt_dst_i | input | ID_W | Destination ID |
| far_req_full_i | input | 1 | Opposite side's request queue is full |
| resp_done_i | input | 1 | A reserved response was sent back |
| req_enq_i | input | 1 | A request was enqueued on this side |
| req_sent_i | input | 1 | A queued request was sent successfully |
| fwd_o | output | 1 | Forward strobe |
| fwd_dst_o | output | ID_W | Destination of forwarded packet |
| fwd_ready_o | output | TIME_W | Time the forwarded packet may go |
| nack_o | output | 1 | Nack strobe |
| nack_cause_o | output | 1 | 0 = far request queue full, 1 = responses full |
| nack_dst_o | output | ID_W | Nack destination (original source) |
| nack_ready_o | output | TIME_W | Time the nack may go |
| resp_cnt_o | output | $clog2(RESP_LIMIT+1) | Outstanding-response count |
| req_cnt_o | output | $clog2(REQ_LIMIT+1) | Queued-request count |
| req_full_o | output | 1 | This side's request queue is full |

## Verification
The bench presents packets that differ only in request, needs-response and already-nacked flags. This separates the far-full cause from the response-full cause, and it separates a reserving forward from a non-reserving one. Requests offered while both conditions hold confirm that the far-full cause wins. Non-request packets offered while far-full is set confirm that they still cross. Current-time values near the top of the range expose any wrong width in the eligibility sums. Counter sequences drive each counter into its limit and into zero, then apply a simultaneous reserve and release, to show that increments and decrements at the limits are dropped and that a same-cycle pair nets to no change.

// File: rtl/bridge_admit_pkg.sv
package bridge_admit_pkg;

    typedef enum logic {
        CAUSE_FAR_REQ_FULL = 1'b0,
        CAUSE_RESP_FULL    = 1'b1
    } nack_cause_e;

    typedef struct packed {
        logic        take;     // a packet was presented
        logic        bounce;   // turn it into a nack
        nack_cause_e cause;
        logic        reserve;  // claim a response slot
    } verdict_t;

    function automatic verdict_t judge(input logic valid, input logic is_req,
                                       input logic needs_resp, input logic nacked,
                                       input logic far_full, input logic resp_full);
        verdict_t v;
        v.take    = valid;
        v.bounce  = 1'b0;
        v.cause   = CAUSE_FAR_REQ_FULL;
        v.reserve = 1'b0;
        if (valid) begin
            if (is_req && far_full) begin
                v.bounce = 1'b1;
                v.cause  = CAUSE_FAR_REQ_FULL;
            end else if (needs_resp && !nacked && resp_full) begin
                v.bounce = 1'b1;
                v.cause  = CAUSE_RESP_FULL;
            end else begin
                v.reserve = needs_resp && !nacked;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/bridge_occ_counter.sv
module bridge_occ_counter #(
    parameter int LIMIT = 4,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          full
);
    logic inc_ok;
    logic dec_ok;

    assign inc_ok = inc && (cnt < CW'(LIMIT));
    assign dec_ok = dec && (cnt != '0);
    assign full   = (cnt >= CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc_ok && !dec_ok) begin
            cnt <= cnt + 1'b1;
        end else if (dec_ok && !inc_ok) begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(LIMIT)); // R8

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && dec && !inc) |=> cnt == '0); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (full && inc && !dec) |=> full); // R8

    AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec && !full) |=> cnt == $past(cnt) + 1'b1); // R7

    AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (inc && dec && !full && cnt != '0) |=> $stable(cnt)); // R6

endmodule

// File: rtl/bridge_admit_decide.sv
module bridge_admit_decide
    import bridge_admit_pkg::*;
(
    input  logic     valid,
    input  logic     is_req,
    input  logic     needs_resp,
    input  logic     nacked,
    input  logic     far_full,
    input  logic     resp_full,
    output verdict_t verdict
);
    always_comb begin
        verdict = judge(valid, is_req, needs_resp, nacked, far_full, resp_full);
    end
endmodule

// File: rtl/bridge_admit.sv
module bridge_admit
    import bridge_admit_pkg::*;
#(
    parameter int TIME_W     = 16,
    parameter int ID_W       = 4,
    parameter int REQ_LIMIT  = 3,
    parameter int RESP_LIMIT = 2,
    parameter int CROSS_DLY  = 10,
    parameter int NACK_DLY   = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [TIME_W-1:0]                 now_i,
    input  logic                              pkt_valid_i,
    input  logic                              pkt_is_req_i,
    input  logic                              pkt_needs_resp_i,
    input  logic                              pkt_nacked_i,
    input  logic [ID_W-1:0]                   pkt_src_i,
    input  logic [ID_W-1:0]                   pkt_dst_i,
    input  logic                              far_req_full_i,
    input  logic                              resp_done_i,
    input  logic                              req_enq_i,
    input  logic                              req_sent_i,
    output logic                              fwd_o,
    output logic [ID_W-1:0]                   fwd_dst_o,
    output logic [TIME_W-1:0]                 fwd_ready_o,
    output logic                              nack_o,
    output logic                              nack_cause_o,
    output logic [ID_W-1:0]                   nack_dst_o,
    output logic [TIME_W-1:0]                 nack_ready_o,
    output logic [$clog2(RESP_LIMIT+1)-1:0]   resp_cnt_o,
    output logic [$clog2(REQ_LIMIT+1)-1:0]    req_cnt_o,
    output logic                              req_full_o
);
    localparam logic [TIME_W-1:0] CROSS_T = TIME_W'(CROSS_DLY);
    localparam logic [TIME_W-1:0] NACK_T  = TIME_W'(NACK_DLY);

    logic     resp_full;
    verdict_t verdict;

    bridge_admit_decide u_decide (
        .valid      (pkt_valid_i),
        .is_req     (pkt_is_req_i),
        .needs_resp (pkt_needs_resp_i),
        .nacked     (pkt_nacked_i),
        .far_full   (far_req_full_i),
        .resp_full  (resp_full),
        .verdict    (verdict)
    );

    bridge_occ_counter #(.LIMIT(RESP_LIMIT)) u_resp_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (verdict.reserve),
        .dec  (resp_done_i),
        .cnt  (resp_cnt_o),
        .full (resp_full)
    );

    bridge_occ_counter #(.LIMIT(REQ_LIMIT)) u_req_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (req_enq_i),
        .dec  (req_sent_i),
        .cnt  (req_cnt_o),
        .full (req_full_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_o        <= 1'b0;
            nack_o       <= 1'b0;
            nack_cause_o <= 1'b0;
            fwd_dst_o    <= '0;
            nack_dst_o   <= '0;
            fwd_ready_o  <= '0;
            nack_ready_o <= '0;
        end else begin
            fwd_o  <= verdict.take && !verdict.bounce;
            nack_o <= verdict.take && verdict.bounce;
            if (verdict.take && !verdict.bounce) begin
                fwd_dst_o   <= pkt_dst_i;
                fwd_ready_o <= now_i + CROSS_T;
            end
            if (verdict.take && verdict.bounce) begin
                nack_cause_o <= verdict.cause;
                nack_dst_o   <= pkt_src_i;
                nack_ready_o <= now_i + NACK_T;
            end
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(fwd_o && nack_o)); // R9

    AST_STROBE_NEEDS_PKT: assert property (@(posedge clk) disable iff (rst)
        !pkt_valid_i |=> !(fwd_o || nack_o)); // R9

    AST_FAR_FULL_NACK: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid_i && pkt_is_req_i && far_req_full_i) |=> (nack_o && nack_cause_o == 1'b0)); // R2

    AST_RESP_FULL_NACK: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid_i && !(pkt_is_req_i && far_req_full_i) && pkt_needs_resp_i
         && !pkt_nacked_i && resp_cnt_o >= RESP_LIMIT) |=> (nack_o && nack_cause_o == 1'b1)); // R3

    AST_NACK_RETURNS: assert property (@(posedge clk) disable iff (rst)
        pkt_valid_i |=> (!nack_o || nack_dst_o == $past(pkt_src_i))); // R5

endmodule

// File: tb/bridge_admit_tb.sv
module bridge_admit_tb;
    localparam int TIME_W = 16;
    localparam int ID_W   = 4;
    localparam int REQ_L  = 3;
    localparam int RESP_L = 2;
    localparam int CROSS  = 10;
    localparam int NACKD  = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic [TIME_W-1:0] now_i;
    logic pkt_valid_i, pkt_is_req_i, pkt_needs_resp_i, pkt_nacked_i;
    logic [ID_W-1:0]   pkt_src_i, pkt_dst_i;
    logic far_req_full_i, resp_done_i, req_enq_i, req_sent_i;
    logic              fwd_o, nack_o, nack_cause_o, req_full_o;
    logic [ID_W-1:0]   fwd_dst_o, nack_dst_o;
    logic [TIME_W-1:0] fwd_ready_o, nack_ready_o;
    logic [1:0]        resp_cnt_o;
    logic [1:0]        req_cnt_o;

    always #10 clk = ~clk; // 50 MHz

    bridge_admit #(.TIME_W(TIME_W), .ID_W(ID_W), .REQ_LIMIT(REQ_L),
                   .RESP_LIMIT(RESP_L), .CROSS_DLY(CROSS), .NACK_DLY(NACKD)) u_dut (
        .clk(clk), .rst(rst), .now_i(now_i),
        .pkt_valid_i(pkt_valid_i), .pkt_is_req_i(pkt_is_req_i),
        .pkt_needs_resp_i(pkt_needs_resp_i), .pkt_nacked_i(pkt_nacked_i),
        .pkt_src_i(pkt_src_i), .pkt_dst_i(pkt_dst_i),
        .far_req_full_i(far_req_full_i), .resp_done_i(resp_done_i),
        .req_enq_i(req_enq_i), .req_sent_i(req_sent_i),
        .fwd_o(fwd_o), .fwd_dst_o(fwd_dst_o), .fwd_ready_o(fwd_ready_o),
        .nack_o(nack_o), .nack_cause_o(nack_cause_o), .nack_dst_o(nack_dst_o),
        .nack_ready_o(nack_ready_o), .resp_cnt_o(resp_cnt_o),
        .req_cnt_o(req_cnt_o), .req_full_o(req_full_o)
    );

    typedef struct {
        logic              is_nack;
        logic              cause;
        logic [ID_W-1:0]   dst;
        logic [TIME_W-1:0] ready;
        string             tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   m_resp   = 0;
    int   m_req    = 0;
    bit   finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Driver: presents one packet, pushes the expected result.
    task automatic send(input logic is_req, input logic needs, input logic nacked,
                        input logic far_full, input logic [ID_W-1:0] src,
                        input logic [ID_W-1:0] dst, input logic [TIME_W-1:0] t,
                        input logic done, input string tag);
        exp_t e;
        @(negedge clk);
        pkt_valid_i = 1'b1; pkt_is_req_i = is_req; pkt_needs_resp_i = needs;
        pkt_nacked_i = nacked; far_req_full_i = far_full; pkt_src_i = src;
        pkt_dst_i = dst; now_i = t; resp_done_i = done;
        e.tag = tag;
        if (is_req && far_full) begin
            e.is_nack = 1'b1; e.cause = 1'b0; e.dst = src; e.ready = t + TIME_W'(NACKD);
        end else if (needs && !nacked && m_resp >= RESP_L) begin
            e.is_nack = 1'b1; e.cause = 1'b1; e.dst = src; e.ready = t + TIME_W'(NACKD);
        end else begin
            e.is_nack = 1'b0; e.cause = 1'b0; e.dst = dst; e.ready = t + TIME_W'(CROSS);
            if (needs && !nacked) m_resp++;
        end
        if (done && m_resp > 0 && !(e.is_nack == 1'b0 && needs && !nacked && m_resp - 1 >= RESP_L))
            m_resp--;
        exp_q.push_back(e);
        @(negedge clk);
        pkt_valid_i = 1'b0; resp_done_i = 1'b0; far_req_full_i = 1'b0;
    endtask

    task automatic pulse(input logic done, input logic enq, input logic sent);
        @(negedge clk);
        resp_done_i = done; req_enq_i = enq; req_sent_i = sent;
        if (done && m_resp > 0) m_resp--;
        if (enq && !sent && m_req < REQ_L) m_req++;
        else if (sent && !enq && m_req > 0) m_req--;
        @(negedge clk);
        resp_done_i = 1'b0; req_enq_i = 1'b0; req_sent_i = 1'b0;
    endtask

    // Monitor: compares every strobe against the scoreboard.
    always @(negedge clk) begin
        if (!rst && (fwd_o || nack_o)) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected strobe", {31'd0, fwd_o}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " one strobe"}, {30'd0, fwd_o, nack_o}, e.is_nack ? 32'd1 : 32'd2);
                if (e.is_nack) begin
                    check({e.tag, " cause"}, {31'd0, nack_cause_o}, {31'd0, e.cause});
                    check({e.tag, " R5 nack dst"}, {28'd0, nack_dst_o}, {28'd0, e.dst});
                    check({e.tag, " R5 nack ready"}, {16'd0, nack_ready_o}, {16'd0, e.ready});
                end else begin
                    check({e.tag, " R4 fwd dst"}, {28'd0, fwd_dst_o}, {28'd0, e.dst});
                    check({e.tag, " R4 fwd ready"}, {16'd0, fwd_ready_o}, {16'd0, e.ready});
                end
            end
        end
    end

    task automatic check_counts(input string tag);
        check({tag, " resp count"}, {30'd0, resp_cnt_o}, m_resp);
        check({tag, " req count"}, {30'd0, req_cnt_o}, m_req);
        check({tag, " R7 req full"}, {31'd0, req_full_o}, (m_req >= REQ_L) ? 32'd1 : 32'd0);
    endtask

    initial begin
        rst = 1'b1; now_i = '0; pkt_valid_i = 0; pkt_is_req_i = 0; pkt_needs_resp_i = 0;
        pkt_nacked_i = 0; pkt_src_i = '0; pkt_dst_i = '0; far_req_full_i = 0;
        resp_done_i = 0; req_enq_i = 0; req_sent_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 fwd idle", {31'd0, fwd_o}, 0);
        check("R1 nack idle", {31'd0, nack_o}, 0);
        check_counts("R1");

        send(0, 0, 0, 0, 4'h2, 4'h7, 16'h0100, 0, "R4 plain response");
        send(1, 1, 0, 0, 4'h3, 4'h9, 16'hFFFA, 0, "R4 wrap forward");
        check_counts("R6 reserve one");
        send(1, 1, 0, 0, 4'h4, 4'hA, 16'h0200, 0, "R6 second reserve");
        check_counts("R6 reserve two");
        send(1, 1, 0, 0, 4'h5, 4'hB, 16'hFFFE, 0, "R3 resp full nack");
        check_counts("R8 resp at limit");
        send(0, 1, 1, 0, 4'h6, 4'hC, 16'h0300, 0, "R6 already nacked passes");
        check_counts("R6 no reserve for nacked");
        send(1, 1, 0, 1, 4'h8, 4'h1, 16'h0400, 0, "R2 priority over R3");
        send(1, 0, 0, 1, 4'hE, 4'h2, 16'h0500, 0, "R2 far full request");
        send(0, 0, 0, 1, 4'hD, 4'h3, 16'h0600, 0, "R2 non-request crosses");
        @(negedge clk);
        check("R9 no strobe when idle", {30'd0, fwd_o, nack_o}, 0);

        pulse(1, 0, 0);
        pulse(1, 0, 0);
        check_counts("R6 released");
        pulse(1, 0, 0);
        check_counts("R8 resp underflow");
        send(1, 1, 0, 0, 4'h1, 4'h5, 16'h0700, 0, "R6 reserve again");
        send(1, 1, 0, 0, 4'h1, 4'h6, 16'h0800, 1, "R6 same-cycle pair");
        check_counts("R6 pair holds");

        pulse(0, 1, 0);
        pulse(0, 1, 0);
        check_counts("R7 two queued");
        pulse(0, 1, 0);
        check_counts("R7 full");
        pulse(0, 1, 0);
        check_counts("R8 req overflow");
        pulse(0, 0, 1);
        check_counts("R7 drained one");
        repeat (3) pulse(0, 0, 1);
        check_counts("R8 req underflow");

        repeat (2) @(negedge clk);
        check("R9 scoreboard empty", exp_q.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule